// File: doc/BRIEF.md
# Paired-Copy Serial Packet Receiver with Output Hold

This block takes a slow asynchronous serial line and recovers packets from it. Each packet holds a 10-bit address and an 8-bit data value. Every packet is sent twice: first a true copy, then a copy whose payload bytes are all bitwise inverted. The address and data outputs change only when both copies agree and the true copy carries a correct checksum.

Each copy on the line starts with one or more preamble bytes. A slow low-then-high filter pulse follows, then a sync byte, then four payload bytes. The byte receiver samples each bit at its midpoint. Its bit counter restarts on the falling edge of every start bit.

Once accepted, the outputs hold through lost, corrupted or mismatched copies, so relays do not chatter. When no good pair has arrived for a configurable hold time, the data lines and the valid flag turn off.

Byte receiver states: `B_IDLE` moves to `B_START` on a falling edge of the line. `B_START` goes back to `B_IDLE` if the line is high at mid start bit (a glitch); otherwise it moves to `B_DATA`. `B_DATA` moves to `B_STOP` after the eighth bit. `B_STOP` returns to `B_IDLE` after it samples the stop bit.

Frame states: `F_HUNT` moves to `F_ARMED` on a preamble byte. `F_ARMED` moves to `F_PAYLOAD` on the sync byte and ignores any other byte. `F_PAYLOAD` returns to `F_HUNT` after the fourth payload byte. A framing error sends every frame state back to `F_HUNT`.

Top module: `pair_frame_rx`

## Requirements
- R1: After reset, `addr_out`, `data_out` and `valid_out` are all 0.
- R2: Each byte has a 0 start bit, 8 data bits sent MSB first, and a 1 stop bit, each lasting CLKS_PER_BIT clocks and sampled near its midpoint. A stop bit read as 0 aborts the copy in progress and returns the frame logic to hunting.
- R3: A copy is recognised only when at least one preamble byte 0xAA comes before the sync byte 0x99. Any other bytes between them (such as those produced by the filter pulse) are ignored. A sync byte with no preamble before it starts nothing.
- R4: The four payload bytes after sync are, in order: address bits 7:0, an address-high byte whose bit 7 is address bit 9 and whose bit 6 is address bit 8 (its bits 5:0 are ignored), the data byte, and the checksum.
- R5: A true copy counts as the first of a pair only if its checksum equals the modulo-256 sum of the first three payload bytes. Otherwise it is discarded.
- R6: The copy that follows an accepted first copy must carry all four payload bytes bitwise inverted. If it does, `addr_out` and `data_out` take the pair's values and `valid_out` becomes 1.
- R7: A copy with a bad checksum, a mismatched or missing second copy, or an aborted copy leaves `addr_out`, `data_out` and `valid_out` unchanged.
- R8: Every validated pair refreshes the outputs and restarts the hold time.
- R9: `valid_out` stays 1 for HOLD_CYCLES clocks after the last validated pair. Then `data_out` and `valid_out` both go to 0 in the same cycle, while `addr_out` keeps its last value.
- R10: After a mismatch or an abort, pairing starts again: the next copy is checked as a true copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| addr_out | output | 10 | Address from the last validated pair |
| data_out | output | 8 | Data from the last validated pair, 0 after timeout |
| valid_out | output | 1 | High while the hold time runs |

## Verification
The bench builds the block with CLKS_PER_BIT = 16 and HOLD_CYCLES = 20000. With these values a full pair takes under 3000 clocks, so a dozen pairs, lost copies, aborts and a full hold expiry all fit in one short run. The hold time spans several pair times, so tests of bad packets are sure to see the held outputs rather than an expiry. The timeout is then checked both just before and just after it lapses.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
    typedef enum logic [1:0] {B_IDLE, B_START, B_DATA, B_STOP} bit_st_t;
    typedef enum logic [1:0] {F_HUNT, F_ARMED, F_PAYLOAD} frm_st_t;
    localparam logic [7:0] PREAMBLE_BYTE = 8'hAA;
    localparam logic [7:0] SYNC_BYTE     = 8'h99;
    localparam int         PAYLOAD_BYTES = 4;
endpackage

// File: rtl/pfr_byte_rx.sv
module pfr_byte_rx
    import pfr_pkg::*;
#(
    parameter int CLKS_PER_BIT = 10417
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_in,
    output logic       byte_stb,
    output logic       byte_err,
    output logic [7:0] byte_q
);
    localparam int CW   = $clog2(CLKS_PER_BIT);
    localparam int HALF = CLKS_PER_BIT / 2;

    bit_st_t        state, nxt;
    logic [1:0]     sync_q;
    logic           rx_s, rx_prev, tick, half;
    logic [CW-1:0]  cnt;
    logic [2:0]     bits;
    logic [7:0]     shreg;

    assign rx_s = sync_q[1];
    assign tick = (cnt == CW'(CLKS_PER_BIT - 1));
    assign half = (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= B_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            B_IDLE:  if (rx_prev && !rx_s)     nxt = B_START;
            B_START: if (half)                 nxt = rx_s ? B_IDLE : B_DATA;
            B_DATA:  if (tick && bits == 3'd7) nxt = B_STOP;
            B_STOP:  if (tick)                 nxt = B_IDLE;
            default:                           nxt = B_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q   <= 2'b11;
            rx_prev  <= 1'b1;
            cnt      <= '0;
            bits     <= '0;
            shreg    <= '0;
            byte_stb <= 1'b0;
            byte_err <= 1'b0;
            byte_q   <= '0;
        end else begin
            sync_q   <= {sync_q[0], rx_in};
            rx_prev  <= rx_s;
            byte_stb <= 1'b0;
            unique case (state)
                B_IDLE: begin
                    cnt  <= '0;
                    bits <= '0;
                end
                B_START: cnt <= half ? '0 : cnt + 1'b1;
                B_DATA: begin
                    cnt <= tick ? '0 : cnt + 1'b1;
                    if (tick) begin
                        shreg <= {shreg[6:0], rx_s};
                        bits  <= bits + 1'b1;
                    end
                end
                B_STOP: begin
                    cnt <= tick ? '0 : cnt + 1'b1;
                    if (tick) begin
                        byte_stb <= 1'b1;
                        byte_err <= !rx_s;
                        byte_q   <= shreg;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // R2: a byte strobe only ever follows the stop-bit state
    a_r2_strobe_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> $past(state) == B_STOP);
endmodule

// File: rtl/pfr_frame_fsm.sv
module pfr_frame_fsm
    import pfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_stb,
    input  logic       byte_err,
    input  logic [7:0] byte_q,
    output logic       pair_ok,
    output logic [9:0] pair_addr,
    output logic [7:0] pair_data
);
    frm_st_t     state, nxt;
    logic [1:0]  idx;
    logic        second;
    logic [7:0]  c0, c1, c2, k0, k1, k2;
    logic        last, first_ok, match;
    logic [7:0]  cur_sum, kept_sum;

    assign cur_sum  = c0 + c1 + c2;
    assign kept_sum = k0 + k1 + k2;
    assign last     = byte_stb && !byte_err && state == F_PAYLOAD
                      && idx == 2'(PAYLOAD_BYTES - 1);
    assign first_ok = (byte_q == cur_sum);
    assign match    = (c0 == ~k0) && (c1 == ~k1) && (c2 == ~k2) && (byte_q == ~kept_sum);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= F_HUNT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (byte_stb) begin
            if (byte_err) nxt = F_HUNT;
            else begin
                unique case (state)
                    F_HUNT:    if (byte_q == PREAMBLE_BYTE) nxt = F_ARMED;
                    F_ARMED:   if (byte_q == SYNC_BYTE)     nxt = F_PAYLOAD;
                    F_PAYLOAD: if (last)                    nxt = F_HUNT;
                    default:                                nxt = F_HUNT;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0; second <= 1'b0; pair_ok <= 1'b0;
            c0 <= '0; c1 <= '0; c2 <= '0; k0 <= '0; k1 <= '0; k2 <= '0;
            pair_addr <= '0; pair_data <= '0;
        end else begin
            pair_ok <= 1'b0;
            if (byte_stb && byte_err) begin
                second <= 1'b0;
                idx    <= '0;
            end else if (byte_stb && state == F_PAYLOAD) begin
                idx <= idx + 1'b1;
                unique case (idx)
                    2'd0: c0 <= byte_q;
                    2'd1: c1 <= byte_q;
                    2'd2: c2 <= byte_q;
                    default: ;
                endcase
                if (last) begin
                    if (!second) begin
                        second <= first_ok;
                        k0 <= c0; k1 <= c1; k2 <= c2;
                    end else begin
                        second    <= 1'b0;
                        pair_ok   <= match;
                        pair_addr <= {k1[7:6], k0};
                        pair_data <= k2;
                    end
                end
            end else if (byte_stb) begin
                idx <= '0;
            end
        end
    end

    // R2, R10: a framing error returns to hunting and forgets a half pair
    a_r2_abort_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && byte_err) |=> (state == F_HUNT && !second));
    // R3: payload is entered only from the armed state
    a_r3_payload_needs_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_PAYLOAD && $past(state) != F_PAYLOAD) |-> $past(state) == F_ARMED);
    // R6: an accepted pair comes from a second copy that finished its payload
    a_r6_pair_from_second: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ok |-> ($past(state) == F_PAYLOAD && $past(second)));
endmodule

// File: rtl/pfr_hold.sv
module pfr_hold #(
    parameter int HOLD_CYCLES = 6500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [9:0] addr_in,
    input  logic [7:0] data_in,
    output logic [9:0] addr_out,
    output logic [7:0] data_out,
    output logic       valid_out
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);

    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            addr_out  <= '0;
            data_out  <= '0;
            valid_out <= 1'b0;
        end else if (load) begin
            cnt       <= HW'(HOLD_CYCLES);
            addr_out  <= addr_in;
            data_out  <= data_in;
            valid_out <= 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == HW'(1)) begin
                data_out  <= '0;
                valid_out <= 1'b0;
            end
        end
    end

    // R9: with the flag down the data lines are off
    a_r9_off_means_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> data_out == '0);
    // R9: the address survives everything except a new pair
    a_r9_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out));
    // R7: while time remains and nothing loads, outputs hold
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt > HW'(1)) |=> ($stable(data_out) && valid_out));
    // R8: a pair restarts the full hold time
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid_out && cnt == HW'(HOLD_CYCLES)));
endmodule

// File: rtl/pair_frame_rx.sv
module pair_frame_rx #(
    parameter int CLKS_PER_BIT = 10417,
    parameter int HOLD_CYCLES  = 6500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_in,
    output logic [9:0] addr_out,
    output logic [7:0] data_out,
    output logic       valid_out
);
    logic       byte_stb, byte_err, pair_ok;
    logic [7:0] byte_q, pair_data;
    logic [9:0] pair_addr;

    pfr_byte_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_byte (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
        .byte_stb(byte_stb), .byte_err(byte_err), .byte_q(byte_q)
    );

    pfr_frame_fsm u_frame (
        .clk(clk), .rst_n(rst_n),
        .byte_stb(byte_stb), .byte_err(byte_err), .byte_q(byte_q),
        .pair_ok(pair_ok), .pair_addr(pair_addr), .pair_data(pair_data)
    );

    pfr_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(pair_ok),
        .addr_in(pair_addr), .data_in(pair_data),
        .addr_out(addr_out), .data_out(data_out), .valid_out(valid_out)
    );
endmodule

// File: tb/pair_frame_rx_test.sv
`timescale 1ns/1ps
module pair_frame_rx_test;
    localparam int CPB  = 16;
    localparam int HOLD = 20000;
    localparam int NF   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [9:0] addr_out;
    logic [7:0] data_out;
    logic       valid_out;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pair_frame_rx #(.CLKS_PER_BIT(CPB), .HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx),
        .addr_out(addr_out), .data_out(data_out), .valid_out(valid_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [9:0] a, input logic [7:0] d, input logic v);
        #2;
        check({req, " addr"}, 32'(addr_out), 32'(a));
        check({req, " data"}, 32'(data_out), 32'(d));
        check({req, " valid"}, 32'(valid_out), 32'(v));
    endtask

    task automatic bit_out(input logic b);
        rx <= b;
        repeat (CPB) @(posedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop);
        bit_out(1'b0);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_out(stop);
    endtask

    // bad_idx: payload byte index sent with a 0 stop bit, ends the copy (-1 none)
    task automatic send_copy(input logic [7:0] b0, b1, b2, b3, input bit inv,
                             input bit pre, input int bad_idx);
        logic [7:0] p [4];
        p[0] = b0; p[1] = b1; p[2] = b2; p[3] = b3;
        if (pre) begin
            send_byte(8'hAA, 1'b1);
            send_byte(8'hAA, 1'b1);
        end
        repeat (NF) bit_out(1'b0);
        repeat (NF) bit_out(1'b1);
        send_byte(8'h99, 1'b1);
        for (int i = 0; i < 4; i++) begin
            send_byte(inv ? ~p[i] : p[i], (i == bad_idx) ? 1'b0 : 1'b1);
            if (i == bad_idx) break;
        end
        repeat (3) bit_out(1'b1);
    endtask

    function automatic logic [7:0] cks(input logic [7:0] a, b, c);
        return a + b + c;
    endfunction

    task automatic send_pair(input logic [9:0] a, input logic [7:0] d);
        logic [7:0] hi;
        hi = {a[9:8], 6'b0};
        send_copy(a[7:0], hi, d, cks(a[7:0], hi, d), 1'b0, 1'b1, -1);
        send_copy(a[7:0], hi, d, cks(a[7:0], hi, d), 1'b1, 1'b1, -1);
    endtask

    task automatic t_reset;
        check_out("R1 reset", 10'h0, 8'h0, 1'b0);
    endtask

    task automatic t_basic;
        send_pair(10'h2C5, 8'h3A);
        check_out("R6 R4 first pair", 10'h2C5, 8'h3A, 1'b1);
    endtask

    task automatic t_refresh;
        send_pair(10'h13F, 8'hE1);
        check_out("R8 refresh", 10'h13F, 8'hE1, 1'b1);
    endtask

    task automatic t_ignored_bits;
        logic [7:0] hi;
        hi = 8'b1010_1101;
        send_copy(8'h42, hi, 8'h77, cks(8'h42, hi, 8'h77), 1'b0, 1'b1, -1);
        send_copy(8'h42, hi, 8'h77, cks(8'h42, hi, 8'h77), 1'b1, 1'b1, -1);
        check_out("R4 low address-high bits ignored", 10'h242, 8'h77, 1'b1);
    endtask

    task automatic t_bad_checksum;
        logic [7:0] bad;
        bad = cks(8'h11, 8'h40, 8'h22) + 8'd1;
        send_copy(8'h11, 8'h40, 8'h22, bad, 1'b0, 1'b1, -1);
        send_copy(8'h11, 8'h40, 8'h22, bad, 1'b1, 1'b1, -1);
        check_out("R5 R7 bad checksum", 10'h242, 8'h77, 1'b1);
    endtask

    task automatic t_mismatch;
        send_copy(8'h05, 8'h80, 8'h55, cks(8'h05, 8'h80, 8'h55), 1'b0, 1'b1, -1);
        send_copy(8'h06, 8'h80, 8'h55, cks(8'h06, 8'h80, 8'h55), 1'b1, 1'b1, -1);
        check_out("R6 R7 mismatched copy", 10'h242, 8'h77, 1'b1);
    endtask

    task automatic t_lost_copy;
        send_copy(8'h33, 8'hC0, 8'h99, cks(8'h33, 8'hC0, 8'h99), 1'b0, 1'b1, -1);
        check_out("R7 lone true copy", 10'h242, 8'h77, 1'b1);
        send_pair(10'h0F0, 8'h5C);
        send_pair(10'h3A5, 8'hC3);
        check_out("R10 realigned after lost copy", 10'h3A5, 8'hC3, 1'b1);
    endtask

    task automatic t_abort;
        send_copy(8'h21, 8'h40, 8'h12, cks(8'h21, 8'h40, 8'h12), 1'b0, 1'b1, -1);
        send_copy(8'h21, 8'h40, 8'h12, cks(8'h21, 8'h40, 8'h12), 1'b1, 1'b1, 2);
        check_out("R2 R7 aborted copy", 10'h3A5, 8'hC3, 1'b1);
        send_pair(10'h1D4, 8'h09);
        check_out("R10 pair after abort", 10'h1D4, 8'h09, 1'b1);
    endtask

    task automatic t_no_preamble;
        send_copy(8'h7E, 8'h00, 8'hF0, cks(8'h7E, 8'h00, 8'hF0), 1'b0, 1'b0, -1);
        send_copy(8'h7E, 8'h00, 8'hF0, cks(8'h7E, 8'h00, 8'hF0), 1'b1, 1'b0, -1);
        check_out("R3 sync without preamble", 10'h1D4, 8'h09, 1'b1);
    endtask

    task automatic t_timeout;
        send_pair(10'h2AA, 8'h81);
        check_out("R8 pair before timeout", 10'h2AA, 8'h81, 1'b1);
        repeat (HOLD - 3000) @(posedge clk);
        check_out("R9 still held before expiry", 10'h2AA, 8'h81, 1'b1);
        repeat (6000) @(posedge clk);
        check_out("R9 cleared after expiry", 10'h2AA, 8'h00, 1'b0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n <= 1'b1;
        repeat (3 * CPB) @(posedge clk);
        t_reset;
        t_basic;
        t_refresh;
        t_ignored_bits;
        t_bad_checksum;
        t_mismatch;
        t_lost_copy;
        t_abort;
        t_no_preamble;
        t_timeout;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule